// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Arbitration

This block is a word-organised memory shared by two independent ports, called left and right. Each port can read or write any word in any cycle. A write can update the upper byte, the lower byte or both, through separate enables. Reads are registered and return data one clock after the address is presented. Each port also has a data-valid output.

When both ports address the same word and at least one of them is writing, the arbiter flags one port as busy and suppresses that port's write. Two reads of the same word never conflict. A role input selects between two modes:
- In master mode the block makes its own busy flags.
- In slave mode it takes busy for each port from outside. Several instances can then run side by side to form wider words, with one master deciding every collision.

A port with its chip enable low does nothing, takes no part in arbitration and is treated as powered down.

Top module: `twin_ram`

## Requirements
- R1: The memory holds 2^AW words of DW bits (default 2048 x 16). A word written through either port is returned by a later read of that word from either port.
- R2: Write enable `*_wr_hi` updates bits [DW-1:DW/2] and `*_wr_lo` updates bits [DW/2-1:0]. Each byte lane is written only when its own enable is high.
- R3: A read access is chip enable high, output enable high and both write enables low. Read data and valid appear on the clock after the address. Valid is high only for a read access whose port was not busy. Data is zero when the port made no read access in the previous cycle.
- R4: Two ports reading the same word in the same cycle never raise busy.
- R5: In master mode, busy is raised when both ports are enabled on the same word and at least one writes. Exactly one port is then busy. When neither port continues an access from the previous cycle, the right port is the busy one.
- R6: A port that was enabled on the same word in the previous cycle continues its access. If only the right port continues, the left port is busy. If both continue, the winner of the previous cycle's collision keeps winning.
- R7: A busy port's write is suppressed in that cycle. Its read data is still returned, with valid low.
- R8: A port with chip enable low writes nothing, never raises busy for itself or the other port, and returns zero data with valid low.
- R9: In slave mode, no arbitration takes place. Each port's busy output equals its busy input, and a busy input suppresses that port's write.
- R10: A read that coincides with a write to the same word returns the contents from before the write.
- R11: When both ports write the same word in the same master-mode cycle, only the winning port's enabled bytes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = make busy internally, 0 = take busy from inputs |
| l_en | input | 1 | Left chip enable |
| l_oe | input | 1 | Left output enable |
| l_wr_hi | input | 1 | Left upper-byte write enable |
| l_wr_lo | input | 1 | Left lower-byte write enable |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when not read |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_in | input | 1 | Left busy from a master (slave mode) |
| l_busy_out | output | 1 | Left busy flag |
| r_en | input | 1 | Right chip enable |
| r_oe | input | 1 | Right output enable |
| r_wr_hi | input | 1 | Right upper-byte write enable |
| r_wr_lo | input | 1 | Right lower-byte write enable |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when not read |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_in | input | 1 | Right busy from a master (slave mode) |
| r_busy_out | output | 1 | Right busy flag |

## Verification
The bench builds the block with AW = 3 and DW = 16, an eight-word memory. This lets it write and read back every word and drive every byte-enable combination at every address. It also runs all sixteen pairings of read, upper, lower and full writes on a shared word, each from three starting histories: both ports fresh, the right port already holding the word, and the left port already holding it. A shadow memory predicts each read, and every later read exposes any write that was suppressed or misapplied. Slave mode is swept over all four busy-input combinations.

// File: rtl/twin_ram_pkg.sv
// Shared definitions for the dual-port memory: the lane count, the role
// encoding and a small helper used by both port controllers.
package twin_ram_pkg;
    localparam int unsigned LANES = 2;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // True when any byte lane of a port asks for a write.
    function automatic logic any_lane(input logic [LANES-1:0] wl);
        return |wl;
    endfunction
endpackage

// File: rtl/twin_ram_port.sv
// Per-port controller. It classifies the port's request as a read or a
// write and gates the byte-lane write strobes with busy. It detects whether
// the port continues an access to the same word from the previous cycle,
// and it registers the read qualifiers for the next cycle.
// Assumes: inputs are synchronous to clk; busy is already resolved.
module twin_ram_port
    import twin_ram_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 oe,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [AW-1:0]        addr,
    input  logic                 busy,
    output logic                 is_wr,
    output logic                 keep,
    output logic [LANES-1:0]     wen,
    output logic                 rd_q,
    output logic                 ok_q
);
    logic [LANES-1:0] lanes;
    logic             rd_now;
    logic             prev_en;
    logic [AW-1:0]    prev_addr;

    assign lanes  = {wr_hi, wr_lo};
    assign is_wr  = en && any_lane(lanes);
    assign rd_now = en && oe && !any_lane(lanes);
    assign keep   = en && prev_en && (addr == prev_addr);
    assign wen    = (en && !busy) ? lanes : '0;

    // Remember the previous access so that continuation can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= en;
            prev_addr <= addr;
        end
    end

    // Register whether data is driven and whether it is valid next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            ok_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
            ok_q <= rd_now && !busy;
        end
    end
endmodule

// File: rtl/twin_ram_arb.sv
// Collision arbiter. A collision is both ports enabled on one word with at
// least one writing. A port continuing its access beats a newcomer. The left
// port wins a fresh tie, and when both continue the previous winner stays.
// In slave mode the external busy inputs pass straight through.
// Assumes: keep flags come from the port controllers of the same cycle.
module twin_ram_arb
    import twin_ram_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  role_e         role,
    input  logic          l_en,
    input  logic          r_en,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    input  logic          l_is_wr,
    input  logic          r_is_wr,
    input  logic          l_keep,
    input  logic          r_keep,
    input  logic          l_busy_in,
    input  logic          r_busy_in,
    output logic          l_busy,
    output logic          r_busy
);
    logic coll;
    logic r_wins;
    logic hold_r;

    assign coll   = (role == ROLE_MASTER) && l_en && r_en &&
                    (l_addr == r_addr) && (l_is_wr || r_is_wr);
    assign r_wins = r_keep && (!l_keep || hold_r);

    // Pick the internal or the external busy source by role.
    always_comb begin
        if (role == ROLE_MASTER) begin
            l_busy = coll && r_wins;
            r_busy = coll && !r_wins;
        end else begin
            l_busy = l_busy_in;
            r_busy = r_busy_in;
        end
    end

    // Record that the right port won this cycle's collision.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_r <= 1'b0;
        else        hold_r <= coll && r_wins;
    end
endmodule

// File: rtl/twin_ram_store.sv
// Storage array with two registered read ports and two byte-laned write
// ports. Reads return the contents from before any write of the same edge.
// Assumes: the arbiter never lets both ports write one lane of one word.
module twin_ram_store
    import twin_ram_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic             clk,
    input  logic [AW-1:0]    l_addr,
    input  logic [DW-1:0]    l_wdata,
    input  logic [LANES-1:0] l_wen,
    input  logic [AW-1:0]    r_addr,
    input  logic [DW-1:0]    r_wdata,
    input  logic [LANES-1:0] r_wen,
    output logic [DW-1:0]    l_q,
    output logic [DW-1:0]    r_q
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned BW    = DW / LANES;

    logic [DW-1:0] mem [DEPTH];

    // Apply the byte-lane writes of both ports.
    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (l_wen[g]) mem[l_addr][g*BW +: BW] <= l_wdata[g*BW +: BW];
            if (r_wen[g]) mem[r_addr][g*BW +: BW] <= r_wdata[g*BW +: BW];
        end
    end

    // Capture the addressed words for both read ports.
    always_ff @(posedge clk) begin
        l_q <= mem[l_addr];
        r_q <= mem[r_addr];
    end
endmodule

// File: rtl/twin_ram.sv
// Top level of the dual-port memory. It joins two port controllers, the
// arbiter and the storage array, and gates read data with the registered
// read qualifiers.
// Assumes: one clock domain, synchronous active-low reset.
module twin_ram
    import twin_ram_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          l_en,
    input  logic          l_oe,
    input  logic          l_wr_hi,
    input  logic          l_wr_lo,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rvalid,
    input  logic          l_busy_in,
    output logic          l_busy_out,
    input  logic          r_en,
    input  logic          r_oe,
    input  logic          r_wr_hi,
    input  logic          r_wr_lo,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rvalid,
    input  logic          r_busy_in,
    output logic          r_busy_out
);
    role_e            role;
    logic             l_is_wr, r_is_wr, l_keep, r_keep;
    logic [LANES-1:0] l_wen, r_wen;
    logic             l_rd_q, r_rd_q;
    logic [DW-1:0]    l_q, r_q;

    assign role = role_e'(master_mode);

    twin_ram_port #(.AW(AW)) u_lport (
        .clk(clk), .rst_n(rst_n), .en(l_en), .oe(l_oe), .wr_hi(l_wr_hi),
        .wr_lo(l_wr_lo), .addr(l_addr), .busy(l_busy_out), .is_wr(l_is_wr),
        .keep(l_keep), .wen(l_wen), .rd_q(l_rd_q), .ok_q(l_rvalid)
    );

    twin_ram_port #(.AW(AW)) u_rport (
        .clk(clk), .rst_n(rst_n), .en(r_en), .oe(r_oe), .wr_hi(r_wr_hi),
        .wr_lo(r_wr_lo), .addr(r_addr), .busy(r_busy_out), .is_wr(r_is_wr),
        .keep(r_keep), .wen(r_wen), .rd_q(r_rd_q), .ok_q(r_rvalid)
    );

    twin_ram_arb #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n), .role(role), .l_en(l_en), .r_en(r_en),
        .l_addr(l_addr), .r_addr(r_addr), .l_is_wr(l_is_wr),
        .r_is_wr(r_is_wr), .l_keep(l_keep), .r_keep(r_keep),
        .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
        .l_busy(l_busy_out), .r_busy(r_busy_out)
    );

    twin_ram_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .l_addr(l_addr), .l_wdata(l_wdata), .l_wen(l_wen),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_wen(r_wen),
        .l_q(l_q), .r_q(r_q)
    );

    // Drive read data only after a read access, zero otherwise.
    assign l_rdata = l_rd_q ? l_q : '0;
    assign r_rdata = r_rd_q ? r_q : '0;
endmodule

// File: rtl/twin_ram_chk.sv
// Protocol checker for the dual-port memory, attached by bind. It watches
// only the top-level ports.
module twin_ram_chk #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_mode,
    input logic          l_en,
    input logic          l_oe,
    input logic          l_wr_hi,
    input logic          l_wr_lo,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_rdata,
    input logic          l_rvalid,
    input logic          l_busy_in,
    input logic          l_busy_out,
    input logic          r_en,
    input logic          r_oe,
    input logic          r_wr_hi,
    input logic          r_wr_lo,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_rvalid,
    input logic          r_busy_in,
    input logic          r_busy_out
);
    logic same_word, any_wr;
    assign same_word = l_en && r_en && (l_addr == r_addr);
    assign any_wr    = l_wr_hi || l_wr_lo || r_wr_hi || r_wr_lo;

    // R5: never both busy in master mode
    assert_one_loser_R5: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !(l_busy_out && r_busy_out));

    // R4: shared reads never conflict
    assert_reads_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && same_word && !any_wr) |-> (!l_busy_out && !r_busy_out));

    // R8: disabled ports cause no busy
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && (!l_en || !r_en)) |-> (!l_busy_out && !r_busy_out));

    // R8: disabled port returns nothing next cycle
    assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |=> (l_rdata == '0 && !l_rvalid));

    // R3: output enable low gives no valid data
    assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && !r_oe) |=> (r_rdata == '0 && !r_rvalid));

    // R7: busy read is marked invalid
    assert_busy_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out |=> !l_rvalid);

    // R9: slave mode passes busy straight through
    assert_slave_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_out == l_busy_in && r_busy_out == r_busy_in));

    // R5: a collision always flags someone
    assert_flag_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && same_word && any_wr) |-> (l_busy_out || r_busy_out));

    // R6: right holder keeps the word while both stay on it
    assert_holder_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && same_word && any_wr && l_busy_out) |=>
        ((master_mode && l_en && r_en && any_wr &&
          l_addr == $past(l_addr) && r_addr == $past(r_addr)) -> l_busy_out));
endmodule

bind twin_ram twin_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_oe(l_oe), .l_wr_hi(l_wr_hi), .l_wr_lo(l_wr_lo),
    .l_addr(l_addr), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_en(r_en), .r_oe(r_oe), .r_wr_hi(r_wr_hi), .r_wr_lo(r_wr_lo),
    .r_addr(r_addr), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
);

// File: tb/twin_ram_bench.sv
// Self-checking bench: an eight-word instance swept against a shadow model.
module twin_ram_bench;
    localparam int unsigned AW = 3;
    localparam int unsigned DW = 16;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic          en;
        logic          oe;
        logic          hi;
        logic          lo;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          bi;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b1;
    logic l_en = 0, l_oe = 0, l_wr_hi = 0, l_wr_lo = 0, l_busy_in = 0;
    logic r_en = 0, r_oe = 0, r_wr_hi = 0, r_wr_lo = 0, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_busy_out, r_busy_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int seq = 0;

    logic [DW-1:0] model [DEPTH];
    logic          p_len = 0, p_ren = 0, p_hold = 0;
    logic [AW-1:0] p_la = '0, p_ra = '0;

    always #5 clk = ~clk;

    twin_ram #(.AW(AW), .DW(DW)) u_twin_ram (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_oe(l_oe), .l_wr_hi(l_wr_hi), .l_wr_lo(l_wr_lo),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_rvalid(l_rvalid), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_en(r_en), .r_oe(r_oe), .r_wr_hi(r_wr_hi), .r_wr_lo(r_wr_lo),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_rvalid(r_rvalid), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 40503 + 12345);
    endfunction

    function automatic req_t rd(input int a);
        return '{en: 1'b1, oe: 1'b1, hi: 1'b0, lo: 1'b0, a: AW'(a), d: '0, bi: 1'b0};
    endfunction

    function automatic req_t wr(input int a, input logic h, input logic l);
        seq++;
        return '{en: 1'b1, oe: 1'b0, hi: h, lo: l, a: AW'(a), d: pat(seq), bi: 1'b0};
    endfunction

    function automatic req_t idle();
        return '{en: 1'b0, oe: 1'b0, hi: 1'b0, lo: 1'b0, a: '0, d: '0, bi: 1'b0};
    endfunction

    // op 0 = read, 1 = upper write, 2 = lower write, 3 = full write
    function automatic req_t op(input int k, input int a);
        return (k == 0) ? rd(a) : wr(a, k[0], k[1]);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input req_t q);
        logic [DW-1:0] n = old;
        if (q.hi) n[DW-1:DW/2] = q.d[DW-1:DW/2];
        if (q.lo) n[DW/2-1:0]  = q.d[DW/2-1:0];
        return n;
    endfunction

    // One clock of stimulus; entered and left at a falling edge.
    task automatic step(input string tag, input logic m, input req_t L, input req_t R);
        logic coll, rwin, lk, rk, bl, br, lrd, rrd;
        logic [DW-1:0] el, er;
        master_mode = m;
        l_en = L.en; l_oe = L.oe; l_wr_hi = L.hi; l_wr_lo = L.lo;
        l_addr = L.a; l_wdata = L.d; l_busy_in = L.bi;
        r_en = R.en; r_oe = R.oe; r_wr_hi = R.hi; r_wr_lo = R.lo;
        r_addr = R.a; r_wdata = R.d; r_busy_in = R.bi;
        #1;
        coll = m && L.en && R.en && (L.a == R.a) && (L.hi || L.lo || R.hi || R.lo);
        lk   = L.en && p_len && (L.a == p_la);
        rk   = R.en && p_ren && (R.a == p_ra);
        rwin = rk && (!lk || p_hold);
        bl   = m ? (coll && rwin) : L.bi;
        br   = m ? (coll && !rwin) : R.bi;
        chk(tag, "l_busy", DW'(l_busy_out), DW'(bl));
        chk(tag, "r_busy", DW'(r_busy_out), DW'(br));
        lrd = L.en && L.oe && !L.hi && !L.lo;
        rrd = R.en && R.oe && !R.hi && !R.lo;
        el  = lrd ? model[L.a] : '0;
        er  = rrd ? model[R.a] : '0;
        if (L.en && !bl) model[L.a] = merge(model[L.a], L);
        if (R.en && !br) model[R.a] = merge(model[R.a], R);
        p_hold = coll && rwin;
        p_len = L.en; p_la = L.a;
        p_ren = R.en; p_ra = R.a;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "l_rdata", l_rdata, el);
        chk(tag, "l_rvalid", DW'(l_rvalid), DW'(lrd && !bl));
        chk(tag, "r_rdata", r_rdata, er);
        chk(tag, "r_rvalid", DW'(r_rvalid), DW'(rrd && !br));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk("R3", "reset rdata", l_rdata | r_rdata, '0);
        chk("R3", "reset rvalid", DW'(l_rvalid | r_rvalid), '0);
        chk("R8", "reset busy", DW'(l_busy_out | r_busy_out), '0);

        // R1: fill every word, then read back on the right port
        for (int a = 0; a < DEPTH; a++) step("R1", 1, wr(a, 1, 1), idle());
        for (int a = 0; a < DEPTH; a++) step("R1", 1, idle(), rd(a));

        // R2: every byte-enable combination at every address
        for (int a = 0; a < DEPTH; a++)
            for (int c = 0; c < 4; c++) begin
                step("R2", 1, wr(a, c[1], c[0]), idle());
                step("R2", 1, idle(), rd(a));
            end

        // R3 and R8: output enable low, chip enable low with writes
        step("R3", 1, '{en: 1, oe: 0, hi: 0, lo: 0, a: 2, d: '0, bi: 0}, rd(2));
        step("R8", 1, '{en: 0, oe: 1, hi: 1, lo: 1, a: 4, d: 16'hBEEF, bi: 0}, rd(4));
        step("R8", 1, rd(4), '{en: 0, oe: 1, hi: 1, lo: 1, a: 4, d: 16'hF00D, bi: 0});
        step("R8", 1, rd(4), rd(4));

        // R4 R5 R6 R7 R10 R11: every op mix from three starting histories
        for (int pre = 0; pre < 3; pre++)
            for (int lm = 0; lm < 4; lm++)
                for (int rm = 0; rm < 4; rm++) begin
                    int a = (lm + rm + pre) % DEPTH;
                    string t;
                    step("R8", 1, idle(), idle());
                    if (pre == 1) step("R6", 1, idle(), op(rm, a));
                    if (pre == 2) step("R6", 1, op(lm, a), idle());
                    if (lm == 0 && rm == 0)      t = "R4";
                    else if (lm != 0 && rm != 0) t = "R11";
                    else if (pre != 0)           t = "R6";
                    else                         t = "R10";
                    step(t, 1, op(lm, a), op(rm, a));
                    step("R6", 1, op(lm, a), op(rm, a));
                    step("R7", 1, rd(a), idle());
                    step("R5", 1, wr(a, 1, 1), wr(a, 1, 1));
                    step("R7", 1, rd(a), rd(a));
                end

        // R9: slave mode, every busy-input pair, distinct words
        for (int b = 0; b < 4; b++) begin
            req_t L = wr(1, 1, 1);
            req_t R = wr(6, 1, 1);
            L.bi = b[1];
            R.bi = b[0];
            step("R9", 0, L, R);
            step("R9", 0, rd(1), rd(6));
            L = rd(6); R = wr(6, 0, 1);
            L.bi = b[0]; R.bi = b[1];
            step("R9", 0, L, R);
            step("R9", 1, rd(6), rd(6));
        end

        // R1: final readback of the whole array on both ports
        for (int a = 0; a < DEPTH; a++) step("R1", 1, rd(a), rd(DEPTH - 1 - a));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule